// File: doc/BRIEF.md
# Indexed Register Access Port with Auto-Advancing Index

This block is the host-facing register access unit of a display controller. The host has a 16-bit data bus, a strobe, a read/write line and a data/command select. When the select is low, a write is a command-phase access and sets an 8-bit register index. When the select is high, accesses are data-phase and go to the register at that index. After each one the index moves forward on its own, so the host can set one index and then stream through a run of registers.

Three data ports are streaming ports and keep the index fixed: the display memory data port, the filter coefficient data port and the gamma table data port. Two of them reach a table through a private pointer. The host loads that pointer through a neighbouring register, and it steps after each access. The block also holds 10-bit coordinates split over a low and a high register, fixed identification values, a divider register stored with an offset, a width register in units of eight pixels, an interrupt status register that is cleared by writing zeros, and a discard counter that makes the port skip a given number of host accesses.

Top module: `idxreg_port`

## Requirements
- R1: A command-phase write (`bus_dsel`=0) loads the register index from `bus_wdata[7:0]`. A command-phase read returns the indexed register and leaves the index unchanged.
- R2: After a data-phase write the index rises by 2, modulo 256. At indices 0x90, 0x5A and 0xB8 the index stays where it is.
- R3: A data-phase read returns the indexed register on `bus_rdata`, with `bus_rvalid` high, in the cycle after the strobe. The index then rises by 1. Unmapped indices read 0 and ignore writes.
- R4: Writing 0x58 loads the filter pointer from `bus_wdata[4:0]`, and reading 0x58 returns it. Each data access to 0x5A reads or writes the 8-bit entry at the pointer and then adds 1 to the pointer. Once the pointer reaches 32, accesses to 0x5A read 0, store nothing and leave the pointer at 32.
- R5: Writing 0xB6 loads the 8-bit gamma pointer, and reading 0xB6 returns it. Each data access to 0xB8 reads or writes one entry of a 256-entry 8-bit table and then adds 1 to the pointer, wrapping from 255 to 0.
- R6: Index 0x00 reads 0xA5 and index 0x02 reads 0x83. Writes to them have no effect.
- R7: A write to 0x04 stores `bus_wdata[5:0]`+1. Reading 0x04 returns the stored value minus 1 with bit 7 set. After reset it reads 0x88.
- R8: The X coordinate is 10 bits: 0x6C holds bits 7:0 and 0x6E holds bits 9:8 in its data bits 1:0. The Y coordinate uses 0x70 and 0x72 in the same way. Each half is written alone, and the high register reads back bits 9:8.
- R9: A write to 0x2A stores a width of `bus_wdata[7:0]`×8. Reading 0x2A returns the width divided by 8. After reset it reads 1.
- R10: Interrupt status bits are set by `irq_set` and cleared by writing 0x F6 with a mask: the new status is the old status AND `bus_wdata[7:0]`. `irq_out` is high while any status bit is set.
- R11: A write to 0xE8 keeps only bits 4, 3, 1 and 0. Reading 0xE8 always returns bit 5 set.
- R12: A data write to 0xFC loads a 4-bit discard count. While the count is nonzero, each strobe is dropped and the count falls by 1. A dropped access changes no state, and a dropped read returns 0 with `bus_rvalid` high. Reading 0xFC returns the count.
- R13: A live data write at 0x90 pulses `mem_wvalid`, with the word on `mem_wdata`, in the next cycle. Reading 0x90 returns 0.
- R14: After reset the index and the discard count are 0, both table pointers are 0, interrupt status is 0 and 0xE8 reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_dsel | input | 1 | 1 = data phase, 0 = command phase |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| irq_set | input | 8 | Sets interrupt status bits |
| irq_out | output | 1 | Any interrupt status bit set |
| mem_wvalid | output | 1 | Display memory word strobe |
| mem_wdata | output | 16 | Display memory word |

## Verification
The hardest state to reach is the interaction of the index advance with the side pointers when both are near their limits. Examples are a filter pointer walking past 31 into its saturated state while the index is held at 0x5A, a gamma pointer wrapping from 255, and a discard count that drops the very access that would have moved either of them. Directed sequences drive the filter pointer through 32 and the gamma pointer through a full lap. A seeded random mix of command loads, data writes and reads, including discard-count loads, then reaches these states in varied orders. A bench-side register model predicts every read word.

// File: rtl/idxreg_pkg.sv
// Package: shared widths, register index map and index helpers for the
// indexed register port. Assumes 8-bit indices and a 16-bit host bus.
package idxreg_pkg;
    localparam int IDX_W = 8;
    localparam int BUS_W = 16;

    localparam logic [IDX_W-1:0] IX_IDA  = 8'h00;
    localparam logic [IDX_W-1:0] IX_IDB  = 8'h02;
    localparam logic [IDX_W-1:0] IX_DIV  = 8'h04;
    localparam logic [IDX_W-1:0] IX_WID  = 8'h2A;
    localparam logic [IDX_W-1:0] IX_FPTR = 8'h58;
    localparam logic [IDX_W-1:0] IX_FDAT = 8'h5A;
    localparam logic [IDX_W-1:0] IX_XLO  = 8'h6C;
    localparam logic [IDX_W-1:0] IX_XHI  = 8'h6E;
    localparam logic [IDX_W-1:0] IX_YLO  = 8'h70;
    localparam logic [IDX_W-1:0] IX_YHI  = 8'h72;
    localparam logic [IDX_W-1:0] IX_MEM  = 8'h90;
    localparam logic [IDX_W-1:0] IX_GPTR = 8'hB6;
    localparam logic [IDX_W-1:0] IX_GDAT = 8'hB8;
    localparam logic [IDX_W-1:0] IX_NDST = 8'hE8;
    localparam logic [IDX_W-1:0] IX_IRQ  = 8'hF6;
    localparam logic [IDX_W-1:0] IX_SKIP = 8'hFC;

    // True for the ports whose index must not move on a data write.
    function automatic logic idx_holds(input logic [IDX_W-1:0] ix);
        return (ix == IX_MEM) || (ix == IX_FDAT) || (ix == IX_GDAT);
    endfunction
endpackage

// File: rtl/idxreg_ctl.sv
// Index and discard control. Holds the register index and the discard
// count, and decides whether the current strobe is live. Assumes that
// skip_ld is only asserted for a live data-phase write.
module idxreg_ctl
    import idxreg_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr,
    input  logic             dsel,
    input  logic [IDX_W-1:0] cmd_val,
    input  logic             skip_ld,
    input  logic [CNT_W-1:0] skip_val,
    output logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] cnt,
    output logic             live
);
    // A strobe is live when no discard is pending.
    always_comb live = en && (cnt == '0);

    // Index advance, command load and discard countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            cnt <= '0;
        end else if (en) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (wr && !dsel) begin
                idx <= cmd_val;
            end else if (wr && dsel) begin
                if (!idx_holds(idx)) idx <= idx + IDX_W'(2);
                if (skip_ld) cnt <= skip_val;
            end else if (dsel) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/idxreg_tbl.sv
// Table with a private self-stepping pointer. BOUNDED=1 gives the pointer
// one extra bit so that it can stop at DEPTH; BOUNDED=0 lets it wrap.
// Assumes DEPTH is a power of two. Memory contents are not reset.
module idxreg_tbl #(
    parameter int DEPTH   = 32,
    parameter int ENT_W   = 8,
    parameter bit BOUNDED = 1'b1,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = BOUNDED ? AW + 1 : AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_ld,
    input  logic [AW-1:0]    ptr_val,
    input  logic             acc,
    input  logic             acc_wr,
    input  logic [ENT_W-1:0] wdata,
    output logic [ENT_W-1:0] rdata,
    output logic [PW-1:0]    ptr
);
    logic [ENT_W-1:0] mem [DEPTH];
    logic             in_range;

    // Range test depends on whether the pointer saturates or wraps.
    generate
        if (BOUNDED) begin : g_sat
            always_comb in_range = !ptr[PW-1];
        end else begin : g_wrap
            always_comb in_range = 1'b1;
        end
    endgenerate

    // Pointer load and post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (ptr_ld)           ptr <= PW'(ptr_val);
        else if (acc && in_range)  ptr <= ptr + 1'b1;
    end

    // Entry write at the current pointer.
    always_ff @(posedge clk) begin
        if (acc && acc_wr && in_range) mem[ptr[AW-1:0]] <= wdata;
    end

    // Entry read at the current pointer, zero when out of range.
    always_comb rdata = in_range ? mem[ptr[AW-1:0]] : '0;
endmodule

// File: rtl/idxreg_bank.sv
// Plain register bank: identification constants, offset divider, width in
// units of eight, split coordinates, non-display status and interrupt
// status. Assumes wr_en is a live data-phase write at index idx.
module idxreg_bank
    import idxreg_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int IRQ_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic [IRQ_W-1:0] irq_set,
    output logic [BUS_W-1:0] rdata,
    output logic [IRQ_W-1:0] irq_stat
);
    localparam int HI_W = COORD_W - 8;

    logic [6:0]         div_q;
    logic [10:0]        wid_q;
    logic [COORD_W-1:0] xc_q, yc_q;
    logic [7:0]         nd_q;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 7'd9;
            wid_q <= 11'd8;
            xc_q  <= '0;
            yc_q  <= '0;
            nd_q  <= '0;
        end else if (wr_en) begin
            case (idx)
                IX_DIV:  div_q <= {1'b0, wdata[5:0]} + 7'd1;
                IX_WID:  wid_q <= {wdata, 3'b000};
                IX_XLO:  xc_q[7:0] <= wdata;
                IX_XHI:  xc_q[COORD_W-1:8] <= wdata[HI_W-1:0];
                IX_YLO:  yc_q[7:0] <= wdata;
                IX_YHI:  yc_q[COORD_W-1:8] <= wdata[HI_W-1:0];
                IX_NDST: nd_q <= wdata & 8'h1B;
                default: ;
            endcase
        end
    end

    // Interrupt status: mask-clear by write, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_stat <= '0;
        else irq_stat <= ((wr_en && idx == IX_IRQ) ? (irq_stat & wdata[IRQ_W-1:0])
                                                   : irq_stat) | irq_set;
    end

    // Readback formatting per register.
    always_comb begin
        case (idx)
            IX_IDA:  rdata = 16'h00A5;
            IX_IDB:  rdata = 16'h0083;
            IX_DIV:  rdata = {8'h00, 1'b1, 7'(div_q - 7'd1)};
            IX_WID:  rdata = {8'h00, wid_q[10:3]};
            IX_XLO:  rdata = {8'h00, xc_q[7:0]};
            IX_XHI:  rdata = BUS_W'(xc_q[COORD_W-1:8]);
            IX_YLO:  rdata = {8'h00, yc_q[7:0]};
            IX_YHI:  rdata = BUS_W'(yc_q[COORD_W-1:8]);
            IX_NDST: rdata = {8'h00, nd_q | 8'h20};
            IX_IRQ:  rdata = BUS_W'(irq_stat);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/idxreg_port.sv
// Top of the indexed register port. Decodes host strobes into command
// loads, data writes and reads, routes them to the index control, the two
// pointer tables and the register bank, and registers read data.
// Assumes one access per strobe cycle and no back-pressure.
module idxreg_port
    import idxreg_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int IRQ_W   = 8,
    parameter int CNT_W   = 4,
    parameter int FDEPTH  = 32,
    parameter int GDEPTH  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic             bus_dsel,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic [IRQ_W-1:0] irq_set,
    output logic             irq_out,
    output logic             mem_wvalid,
    output logic [15:0]      mem_wdata
);
    localparam int FAW = $clog2(FDEPTH);
    localparam int FPW = FAW + 1;
    localparam int GAW = $clog2(GDEPTH);

    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] skip_cnt;
    logic             live, dat_wr, dat_acc;
    logic [FPW-1:0]   fptr;
    logic [GAW-1:0]   gptr;
    logic [7:0]       f_rd, g_rd;
    logic [BUS_W-1:0] bank_rd, rd_mux;
    logic [IRQ_W-1:0] irq_stat;

    // Qualified access kinds.
    always_comb begin
        dat_acc = live && bus_dsel;
        dat_wr  = dat_acc && bus_wr;
    end

    idxreg_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en(bus_en), .wr(bus_wr), .dsel(bus_dsel),
        .cmd_val(bus_wdata[7:0]),
        .skip_ld(dat_wr && idx == IX_SKIP), .skip_val(bus_wdata[CNT_W-1:0]),
        .idx(idx), .cnt(skip_cnt), .live(live)
    );

    idxreg_tbl #(.DEPTH(FDEPTH), .ENT_W(8), .BOUNDED(1'b1)) u_ftbl (
        .clk(clk), .rst_n(rst_n),
        .ptr_ld(dat_wr && idx == IX_FPTR), .ptr_val(bus_wdata[FAW-1:0]),
        .acc(dat_acc && idx == IX_FDAT), .acc_wr(bus_wr),
        .wdata(bus_wdata[7:0]), .rdata(f_rd), .ptr(fptr)
    );

    idxreg_tbl #(.DEPTH(GDEPTH), .ENT_W(8), .BOUNDED(1'b0)) u_gtbl (
        .clk(clk), .rst_n(rst_n),
        .ptr_ld(dat_wr && idx == IX_GPTR), .ptr_val(bus_wdata[GAW-1:0]),
        .acc(dat_acc && idx == IX_GDAT), .acc_wr(bus_wr),
        .wdata(bus_wdata[7:0]), .rdata(g_rd), .ptr(gptr)
    );

    idxreg_bank #(.COORD_W(COORD_W), .IRQ_W(IRQ_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(dat_wr),
        .wdata(bus_wdata[7:0]), .irq_set(irq_set),
        .rdata(bank_rd), .irq_stat(irq_stat)
    );

    // Read source selection by index.
    always_comb begin
        case (idx)
            IX_FPTR: rd_mux = BUS_W'(fptr);
            IX_FDAT: rd_mux = {8'h00, f_rd};
            IX_GPTR: rd_mux = BUS_W'(gptr);
            IX_GDAT: rd_mux = {8'h00, g_rd};
            IX_SKIP: rd_mux = BUS_W'(skip_cnt);
            IX_MEM:  rd_mux = '0;
            default: rd_mux = bank_rd;
        endcase
    end

    // Registered read return and display memory strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            mem_wvalid <= 1'b0;
            mem_wdata  <= '0;
        end else begin
            bus_rvalid <= bus_en && !bus_wr;
            if (bus_en && !bus_wr) bus_rdata <= live ? rd_mux : '0;
            mem_wvalid <= dat_wr && idx == IX_MEM;
            if (dat_wr && idx == IX_MEM) mem_wdata <= bus_wdata;
        end
    end

    always_comb irq_out = |irq_stat;
endmodule

// File: rtl/idxreg_chk.sv
// Assertion checker for idxreg_port, attached by bind. Observes the index,
// discard count and filter pointer inside the top module.
module idxreg_chk
    import idxreg_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int FPW   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr,
    input logic             dsel,
    input logic [15:0]      wdata,
    input logic [IDX_W-1:0] idx,
    input logic [CNT_W-1:0] cnt,
    input logic             live,
    input logic             mem_wvalid,
    input logic [FPW-1:0]   fptr
);
    p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr && !dsel) |=> idx == $past(wdata[7:0]));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr && dsel && idx_holds(idx)) |=> $stable(idx));

    p_step2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr && dsel && !idx_holds(idx)) |=> idx == $past(idx) + IDX_W'(2));

    p_step1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !wr && dsel) |=> idx == $past(idx) + IDX_W'(1));

    p_discard_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != '0) |=> ($stable(idx) && cnt == $past(cnt) - 1'b1));

    p_memw_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> $past(live && wr && dsel && idx == IX_MEM));

    p_fptr_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fptr <= FPW'(32));
endmodule

bind idxreg_port idxreg_chk #(.CNT_W(CNT_W), .FPW(FPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(bus_en), .wr(bus_wr), .dsel(bus_dsel),
    .wdata(bus_wdata), .idx(idx), .cnt(skip_cnt), .live(live),
    .mem_wvalid(mem_wvalid), .fptr(fptr)
);

// File: tb/idxreg_port_tb_top.sv
`timescale 1ns/1ps
// Bench for idxreg_port: directed corner cases plus seeded random traffic,
// compared against a register model held in the bench.
module idxreg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0, bus_dsel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  irq_set = '0;
    logic        irq_out, mem_wvalid;
    logic [15:0] mem_wdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench register model.
    int m_idx, m_cnt, m_div, m_wid, m_xs, m_ys, m_nd, m_irq, m_fp, m_gp;
    int m_f [32];
    int m_g [256];

    always #2 clk = ~clk;

    idxreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_dsel(bus_dsel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_set(irq_set), .irq_out(irq_out),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (idx model 0x%0h)",
                     tag, act, exp, m_idx);
        end
    endtask

    function automatic bit holds(input int ix);
        return ix == 'h90 || ix == 'h5A || ix == 'hB8;
    endfunction

    function automatic int mdl_read(input int ix);
        case (ix)
            'h00: return 'hA5;
            'h02: return 'h83;
            'h04: return ((m_div - 1) & 127) | 128;
            'h2A: return (m_wid >> 3) & 255;
            'h58: return m_fp;
            'h5A: return (m_fp < 32) ? m_f[m_fp] : 0;
            'h6C: return m_xs & 255;
            'h6E: return m_xs >> 8;
            'h70: return m_ys & 255;
            'h72: return m_ys >> 8;
            'hB6: return m_gp;
            'hB8: return m_g[m_gp];
            'hE8: return m_nd | 'h20;
            'hF6: return m_irq;
            'hFC: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic mdl_write(input int ix, input int v);
        case (ix)
            'h04: m_div = (v & 63) + 1;
            'h2A: m_wid = (v & 255) << 3;
            'h58: m_fp = v & 31;
            'h5A: if (m_fp < 32) begin m_f[m_fp] = v & 255; m_fp++; end
            'h6C: m_xs = (m_xs & 'h300) | (v & 255);
            'h6E: m_xs = (m_xs & 255) | ((v & 3) << 8);
            'h70: m_ys = (m_ys & 'h300) | (v & 255);
            'h72: m_ys = (m_ys & 255) | ((v & 3) << 8);
            'hB6: m_gp = v & 255;
            'hB8: begin m_g[m_gp] = v & 255; m_gp = (m_gp + 1) & 255; end
            'hE8: m_nd = v & 'h1B;
            'hF6: m_irq = m_irq & v & 255;
            'hFC: m_cnt = v & 15;
            default: ;
        endcase
    endtask

    // One write strobe; checks the display memory strobe (R13).
    task automatic do_wr(input bit dsel, input int v);
        bit exp_mem;
        exp_mem = 0;
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_dsel = dsel; bus_wdata = 16'(v);
        if (m_cnt > 0) m_cnt--;
        else if (!dsel) m_idx = v & 255;
        else begin
            exp_mem = (m_idx == 'h90);
            mdl_write(m_idx, v);
            if (!holds(m_idx)) m_idx = (m_idx + 2) & 255;
        end
        @(negedge clk);
        bus_en = 0;
        check(int'(mem_wvalid), int'(exp_mem), "R13 mem_wvalid");
        if (exp_mem) check(int'(mem_wdata), v & 'hFFFF, "R13 mem_wdata");
    endtask

    // One read strobe; compares the returned word with the model.
    task automatic do_rd(input bit dsel, input string tag);
        int exp;
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_dsel = dsel;
        if (m_cnt > 0) begin
            exp = 0; m_cnt--;
        end else begin
            exp = mdl_read(m_idx);
            if (dsel) begin
                if (m_idx == 'h5A && m_fp < 32) m_fp++;
                if (m_idx == 'hB8) m_gp = (m_gp + 1) & 255;
                m_idx = (m_idx + 1) & 255;
            end
        end
        @(negedge clk);
        bus_en = 0;
        check(int'(bus_rvalid), 1, {tag, " rvalid"});
        check(int'(bus_rdata), exp, tag);
    endtask

    task automatic rd_at(input int ix, input string tag);
        do_wr(0, ix);
        do_rd(1, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        m_idx = 0; m_cnt = 0; m_div = 9; m_wid = 8; m_xs = 0; m_ys = 0;
        m_nd = 0; m_irq = 0; m_fp = 0; m_gp = 0;
        foreach (m_f[i]) m_f[i] = 0;
        foreach (m_g[i]) m_g[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R14 reset state: index 0 reads the first identification word.
        @(negedge clk);
        check(int'(irq_out), 0, "R14 irq_out after reset");
        do_rd(1, "R14 index 0 after reset / R6 id A");
        do_rd(1, "R3 odd index reads 0");
        do_rd(1, "R6 id B");
        rd_at('h04, "R14 R7 divider reset value");
        rd_at('h2A, "R14 R9 width reset value");
        rd_at('hE8, "R14 R11 status reset value");
        rd_at('hFC, "R14 R12 discard reset value");
        rd_at('h58, "R14 R4 filter pointer reset");

        // R1 command read does not advance the index.
        do_wr(0, 'h02);
        do_rd(0, "R1 command read");
        do_rd(0, "R1 command read twice");
        // R6 writes ignored.
        do_wr(0, 'h00); do_wr(1, 'h1234);
        rd_at('h00, "R6 id A after write");

        // R7 divider and R9 width through a streamed run.
        do_wr(0, 'h04); do_wr(1, 'hFF);
        rd_at('h04, "R7 divider max field");
        do_wr(0, 'h2A); do_wr(1, 'h3C);
        rd_at('h2A, "R9 width");

        // R8 split coordinates, R2 index advance across neighbours.
        do_wr(0, 'h6C);
        do_wr(1, 'hAB); do_wr(1, 'hFE); do_wr(1, 'h12); do_wr(1, 'h01);
        do_wr(0, 'h6C);
        do_rd(1, "R8 x low"); do_rd(1, "R3 odd"); do_rd(1, "R8 x high");
        do_rd(1, "R3 odd"); do_rd(1, "R8 y low"); do_rd(1, "R3 odd");
        do_rd(1, "R8 y high");
        do_wr(0, 'h6E); do_wr(1, 'h02);
        rd_at('h6C, "R8 low kept after high write");
        rd_at('h6E, "R8 high rewritten");

        // R11 status mask and forced bit.
        do_wr(0, 'hE8); do_wr(1, 'hFF);
        rd_at('hE8, "R11 status masked");

        // R4 filter table: fill, read back, saturate at 32.
        do_wr(0, 'h58); do_wr(1, 'h20);
        rd_at('h58, "R4 pointer load masked to 5 bits");
        do_wr(0, 'h5A);
        for (int i = 0; i < 32; i++) do_wr(1, 'h40 + i);
        rd_at('h58, "R4 pointer saturated at 32");
        do_wr(0, 'h5A); do_wr(1, 'h77);
        do_rd(1, "R4 read beyond end is 0");
        rd_at('h58, "R4 pointer still 32");
        do_wr(0, 'h58); do_wr(1, 'h1E);
        do_wr(0, 'h5A);
        do_rd(0, "R4 command read of entry 30");
        do_wr(1, 'h99);
        do_wr(0, 'h5A);
        do_rd(1, "R2 R4 data read entry 31 after held write");
        do_wr(0, 'h58); do_wr(1, 0);
        do_wr(0, 'h5A); do_rd(1, "R4 entry 0");

        // R5 gamma table full lap with wrap.
        do_wr(0, 'hB6); do_wr(1, 'hFF);
        do_wr(0, 'hB8);
        for (int i = 0; i < 256; i++) do_wr(1, (i * 37 + 11) & 255);
        rd_at('hB6, "R5 pointer wrapped to 255");
        do_wr(0, 'hB6); do_wr(1, 'h00);
        do_wr(0, 'hB8); do_rd(1, "R5 entry 0");
        do_wr(0, 'hB8); do_rd(1, "R5 entry 1");

        // R13 memory port streaming, read returns 0.
        do_wr(0, 'h90);
        do_wr(1, 'hBEEF); do_wr(1, 'h1234);
        rd_at('h90, "R13 memory port read");

        // R10 interrupt status set and mask clear.
        @(negedge clk); irq_set = 8'hA5;
        @(negedge clk); irq_set = 8'h00; m_irq |= 'hA5;
        check(int'(irq_out), 1, "R10 irq_out set");
        do_wr(0, 'hF6); do_wr(1, 'h0F);
        rd_at('hF6, "R10 masked clear");
        do_wr(0, 'hF6); do_wr(1, 'h00);
        check(int'(irq_out), 0, "R10 irq_out cleared");

        // R12 discard count: dropped accesses change nothing.
        do_wr(0, 'hFC); do_wr(1, 3);
        do_wr(0, 'h04);
        do_rd(1, "R12 dropped read");
        do_wr(1, 'h22);
        rd_at('hFC, "R12 index kept past discards");
        rd_at('h04, "R12 divider untouched");

        // Random mix over the map.
        for (int n = 0; n < 3000; n++) begin
            int ixs [18] = '{'h00, 'h02, 'h04, 'h2A, 'h58, 'h5A, 'h6C, 'h6E,
                             'h70, 'h72, 'h90, 'hB6, 'hB8, 'hE8, 'hF6, 'hFC,
                             'h05, 'h91};
            int r;
            r = $urandom_range(0, 9);
            if (r < 3)      do_wr(0, ixs[$urandom_range(0, 17)]);
            else if (r < 6) do_wr(1, (m_idx == 'hFC) ? $urandom_range(0, 3)
                                                     : int'($urandom_range(0, 65535)));
            else if (r < 9) do_rd(1, "R2 R3 R12 random data read");
            else            do_rd(0, "R1 random command read");
        end

        finish_run();
    end
endmodule